// File: doc/BRIEF.md
# DRAM Bank State Activity Monitor

This block sits beside a DRAM controller and watches the command stream it sends. Each command carries an opcode, a target bank and a cycle timestamp. The monitor keeps one open/closed bit per bank and a small device-level state machine. From these it accumulates the statistics a power or performance model needs:

- per-bank counts of activates, reads, writes, precharges and single-bank refreshes;
- per-bank open time;
- device-wide open and closed cycle totals;
- an all-bank refresh count.

Any command that does not fit the current bank state produces a one-cycle violation pulse. Timestamps are expected to be non-decreasing. Every elapsed-time difference is clamped at zero before it is added. Every counter is 32 bits wide and stops at its maximum value instead of wrapping. The refresh timing values (tRFC, tRP, tRAS) are static inputs.

The device state machine has two states. ST_QUIET means no bank is open. ST_OPEN means at least one bank is open. It has four named transitions:

- T_WAKE goes from ST_QUIET to ST_OPEN on an activate.
- T_DRAIN goes from ST_OPEN to ST_QUIET on a precharge that closes the last open bank.
- T_SWEEP goes from ST_OPEN to ST_QUIET on a precharge-all.
- T_REFRESH goes from ST_OPEN to ST_QUIET on an all-bank refresh.

In every other case the state holds.

The per-bank counters are read through a combinational select port, so the block does not need a wide output bus.

Top module: `dram_bank_monitor`

## Requirements
- R1: After a synchronous reset all counters read zero, every bank is closed, `device_open` and `violation` are low, and `cmd_ready` is high from the first clock edge after reset is released. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- R2: `cmd_op` encodes 0 = activate, 1 = read, 2 = write, 3 = precharge, 4 = precharge-all, 5 = all-bank refresh, 6 = single-bank refresh, 7 = reserved. An activate to a closed bank adds one to that bank's activate count, marks the bank open and records the command timestamp as the bank's open time. An activate to an open bank changes nothing and raises the violation.
- R3: An activate accepted while no bank is open starts a device-wide open period at its timestamp. It also adds the time since the current closed-period start to the device closed-cycle total.
- R4: A read or write adds one to the target bank's read or write count whether or not the bank is open. If the bank is closed, the violation is also raised.
- R5: A precharge to an open bank adds one to its precharge count, adds (timestamp − open time) to its open-cycle count and closes it. If it was the only open bank, the device open total also gains (timestamp − device open start), and a new closed period starts at this timestamp. A precharge to a closed bank changes nothing and raises the violation.
- R6: A precharge-all with at least one bank open applies the per-bank precharge accounting of R5 to every open bank. It then adds the device open interval, starts a closed period at this timestamp and closes all banks. With no bank open it only raises the violation.
- R7: An all-bank refresh does the following:
  - adds one to the refresh count;
  - adds the time since the closed-period start to the device closed total;
  - adds K = max(0, tRFC − tRP) to the device open total and to every bank's open-cycle count;
  - moves the closed-period start to timestamp + K;
  - closes all banks.
  It also raises the violation if any bank was open.
- R8: A single-bank refresh to a closed bank adds one to its refresh count and tRAS + tRP to its open-cycle count. If the bank is open, the command changes nothing and raises the violation.
- R9: Every elapsed-time difference that would be negative is added as zero. For example, an activate issued before the closed-period start that a refresh pushed into the future adds zero.
- R10: Every counter saturates at 2^32 − 1 instead of wrapping.
- R11: `violation` is high in the cycle after an offending command is accepted, and low otherwise. Opcode 7 raises it and changes nothing else. With `cmd_valid` low, nothing changes.
- R12: `device_open` shows the state machine: high in ST_OPEN, low in ST_QUIET. It is high exactly when at least one bank is open.
- R13: `stat_value` returns, for bank `stat_bank`, the statistic chosen by `stat_kind`: 0 = activates, 1 = reads, 2 = writes, 3 = precharges, 4 = single-bank refreshes, 5 = open cycles. Values 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command opcode (R2) |
| cmd_bank | input | BANK_W | Target bank |
| cmd_ts | input | 32 | Command timestamp in cycles |
| t_rfc | input | TIM_W | Refresh cycle time |
| t_rp | input | TIM_W | Precharge time |
| t_ras | input | TIM_W | Activate-to-precharge time |
| stat_bank | input | BANK_W | Bank selected for readout |
| stat_kind | input | 3 | Statistic selected for readout (R13) |
| stat_value | output | 32 | Selected per-bank statistic |
| bank_open | output | NUM_BANKS | Per-bank open bit |
| device_open | output | 1 | Device state machine in ST_OPEN |
| dev_active_cycles | output | 32 | Device-wide open cycle total |
| dev_precharge_cycles | output | 32 | Device-wide closed cycle total |
| refresh_count | output | 32 | All-bank refresh count |
| violation | output | 1 | Protocol violation pulse |

## Verification
A directed sequence takes the main accounting paths with hand-computed totals:

- one bank opening and closing, which separates per-bank intervals from the device interval;
- two overlapping banks, which shows whether only the last precharge closes the device period;
- precharge-all over several open banks;
- a refresh followed by an early activate, which shows the clamp at zero.

Deliberately illegal commands show whether a violation also leaves state untouched or is still counted, as reads and writes are. Reserved opcodes and idle cycles are included. A long random stream with small timestamp steps mixes every opcode and bank, and a behavioural model compares every output and a rotating statistic on every clock. A final burst near the top of the timestamp range drives an open-cycle counter into saturation.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    localparam int CNT_W = 32;
    localparam int TS_W  = 32;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4,
        OP_REF  = 3'd5,
        OP_REFB = 3'd6,
        OP_RSVD = 3'd7
    } dbm_op_e;

    typedef enum logic [2:0] {
        SK_ACT  = 3'd0,
        SK_RD   = 3'd1,
        SK_WR   = 3'd2,
        SK_PRE  = 3'd3,
        SK_REFB = 3'd4,
        SK_CYC  = 3'd5,
        SK_NA6  = 3'd6,
        SK_NA7  = 3'd7
    } dbm_kind_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_OPEN  = 1'b1
    } dbm_state_e;

    // saturating accumulate of a (CNT_W+1)-bit increment
    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] acc,
                                                 input logic [CNT_W:0]   inc);
        logic [CNT_W+1:0] sum;
        sum = {2'b00, acc} + {1'b0, inc};
        if (sum > {2'b00, {CNT_W{1'b1}}})
            return {CNT_W{1'b1}};
        return sum[CNT_W-1:0];
    endfunction

    // elapsed time from 'since' to 'now', clamped at zero
    function automatic logic [TS_W:0] gap(input logic [TS_W-1:0] now,
                                          input logic [TS_W:0]   since);
        if ({1'b0, now} >= since)
            return {1'b0, now} - since;
        return '0;
    endfunction

endpackage

// File: rtl/dbm_bank_slot.sv
module dbm_bank_slot
    import dbm_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int IDX    = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  dbm_op_e             op,
    input  logic [BANK_W-1:0]   bank,
    input  logic [TS_W-1:0]     ts,
    input  logic [CNT_W:0]      ref_chg,
    input  logic [CNT_W:0]      refb_chg,
    input  logic [2:0]          kind,
    output logic                is_open,
    output logic [CNT_W-1:0]    stat
);

    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    logic              hit;
    logic              open_q;
    logic [TS_W-1:0]   open_ts_q;
    logic [CNT_W-1:0]  act_q, rd_q, wr_q, pre_q, refb_q, cyc_q;

    assign hit     = fire && (bank == BANK_W'(IDX));
    assign is_open = open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            open_ts_q <= '0;
            act_q     <= '0;
            rd_q      <= '0;
            wr_q      <= '0;
            pre_q     <= '0;
            refb_q    <= '0;
            cyc_q     <= '0;
        end else if (fire) begin
            unique case (op)
                OP_ACT: begin
                    if (hit && !open_q) begin
                        act_q     <= sat_add(act_q, ONE);
                        open_q    <= 1'b1;
                        open_ts_q <= ts;
                    end
                end
                OP_RD: begin
                    if (hit) rd_q <= sat_add(rd_q, ONE);
                end
                OP_WR: begin
                    if (hit) wr_q <= sat_add(wr_q, ONE);
                end
                OP_PRE: begin
                    if (hit && open_q) begin
                        pre_q  <= sat_add(pre_q, ONE);
                        cyc_q  <= sat_add(cyc_q, gap(ts, {1'b0, open_ts_q}));
                        open_q <= 1'b0;
                    end
                end
                OP_PREA: begin
                    if (open_q) begin
                        pre_q  <= sat_add(pre_q, ONE);
                        cyc_q  <= sat_add(cyc_q, gap(ts, {1'b0, open_ts_q}));
                        open_q <= 1'b0;
                    end
                end
                OP_REF: begin
                    cyc_q  <= sat_add(cyc_q, ref_chg);
                    open_q <= 1'b0;
                end
                OP_REFB: begin
                    if (hit && !open_q) begin
                        refb_q <= sat_add(refb_q, ONE);
                        cyc_q  <= sat_add(cyc_q, refb_chg);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (dbm_kind_e'(kind))
            SK_ACT:  stat = act_q;
            SK_RD:   stat = rd_q;
            SK_WR:   stat = wr_q;
            SK_PRE:  stat = pre_q;
            SK_REFB: stat = refb_q;
            SK_CYC:  stat = cyc_q;
            default: stat = '0;
        endcase
    end

    // R7: an all-bank refresh leaves this bank closed
    p_closed_after_ref_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_REF) |=> !open_q);

    // R8: single-bank refresh to an open bank touches no counter
    p_refb_open_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && op == OP_REFB && open_q) |=> ($stable(refb_q) && $stable(cyc_q)));

    // R10: open-cycle and activate counters never wrap back
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= $past(cyc_q)) && (act_q >= $past(act_q)));

endmodule

// File: rtl/dbm_device_ctl.sv
module dbm_device_ctl
    import dbm_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire,
    input  dbm_op_e               op,
    input  logic [TS_W-1:0]       ts,
    input  logic                  tgt_open,
    input  logic [NUM_BANKS-1:0]  bank_open,
    input  logic [CNT_W:0]        ref_chg,
    output logic                  dev_open,
    output logic [CNT_W-1:0]      dev_act,
    output logic [CNT_W-1:0]      dev_pre,
    output logic [CNT_W-1:0]      ref_cnt,
    output logic                  viol
);

    localparam int OC_W = $clog2(NUM_BANKS + 1);
    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    dbm_state_e        state_q, state_nx;
    logic [OC_W-1:0]   open_cnt;
    logic              one_open;
    logic [TS_W-1:0]   first_q;
    logic [TS_W:0]     last_pre_q;
    logic [CNT_W-1:0]  dev_act_q, dev_pre_q, ref_q;
    logic              viol_q;

    always_comb begin
        open_cnt = '0;
        for (int i = 0; i < NUM_BANKS; i++)
            open_cnt = open_cnt + OC_W'(bank_open[i]);
    end
    assign one_open = (open_cnt == OC_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_QUIET;
        else     state_q <= state_nx;
    end

    // transitions: T_WAKE, T_DRAIN, T_SWEEP, T_REFRESH
    always_comb begin
        state_nx = state_q;
        if (fire) begin
            unique case (state_q)
                ST_QUIET: begin
                    if (op == OP_ACT) state_nx = ST_OPEN;                 // T_WAKE
                end
                ST_OPEN: begin
                    if (op == OP_PRE && tgt_open && one_open) state_nx = ST_QUIET; // T_DRAIN
                    else if (op == OP_PREA) state_nx = ST_QUIET;          // T_SWEEP
                    else if (op == OP_REF)  state_nx = ST_QUIET;          // T_REFRESH
                end
                default: state_nx = ST_QUIET;
            endcase
        end
    end

    // outputs and device accounting
    always_ff @(posedge clk) begin
        if (rst) begin
            first_q    <= '0;
            last_pre_q <= '0;
            dev_act_q  <= '0;
            dev_pre_q  <= '0;
            ref_q      <= '0;
            viol_q     <= 1'b0;
        end else begin
            viol_q <= 1'b0;
            if (fire) begin
                unique case (op)
                    OP_ACT: begin
                        if (tgt_open) begin
                            viol_q <= 1'b1;
                        end else if (state_q == ST_QUIET) begin
                            first_q   <= ts;
                            dev_pre_q <= sat_add(dev_pre_q, gap(ts, last_pre_q));
                        end
                    end
                    OP_RD, OP_WR: viol_q <= !tgt_open;
                    OP_PRE: begin
                        if (!tgt_open) begin
                            viol_q <= 1'b1;
                        end else if (one_open) begin
                            dev_act_q  <= sat_add(dev_act_q, gap(ts, {1'b0, first_q}));
                            last_pre_q <= {1'b0, ts};
                        end
                    end
                    OP_PREA: begin
                        if (state_q == ST_QUIET) begin
                            viol_q <= 1'b1;
                        end else begin
                            dev_act_q  <= sat_add(dev_act_q, gap(ts, {1'b0, first_q}));
                            last_pre_q <= {1'b0, ts};
                        end
                    end
                    OP_REF: begin
                        viol_q     <= (state_q == ST_OPEN);
                        ref_q      <= sat_add(ref_q, ONE);
                        dev_pre_q  <= sat_add(dev_pre_q, gap(ts, last_pre_q));
                        last_pre_q <= {1'b0, ts} + ref_chg;
                        dev_act_q  <= sat_add(dev_act_q, ref_chg);
                    end
                    OP_REFB: viol_q <= tgt_open;
                    default: viol_q <= 1'b1;
                endcase
            end
        end
    end

    assign dev_open = (state_q == ST_OPEN);
    assign dev_act  = dev_act_q;
    assign dev_pre  = dev_pre_q;
    assign ref_cnt  = ref_q;
    assign viol     = viol_q;

    // R12: state machine agrees with the per-bank open bits
    p_state_matches_banks_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPEN) == (|bank_open));

    // R2: activate to an open bank is flagged
    p_dup_act_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_ACT && tgt_open) |=> viol_q);

    // R6: precharge-all always leaves the device quiet
    p_quiet_after_prea_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && op == OP_PREA) |=> (state_q == ST_QUIET));

endmodule

// File: rtl/dram_bank_monitor.sv
module dram_bank_monitor
    import dbm_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int TIM_W     = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [2:0]            cmd_op,
    input  logic [BANK_W-1:0]     cmd_bank,
    input  logic [31:0]           cmd_ts,
    input  logic [TIM_W-1:0]      t_rfc,
    input  logic [TIM_W-1:0]      t_rp,
    input  logic [TIM_W-1:0]      t_ras,
    input  logic [BANK_W-1:0]     stat_bank,
    input  logic [2:0]            stat_kind,
    output logic [31:0]           stat_value,
    output logic [NUM_BANKS-1:0]  bank_open,
    output logic                  device_open,
    output logic [31:0]           dev_active_cycles,
    output logic [31:0]           dev_precharge_cycles,
    output logic [31:0]           refresh_count,
    output logic                  violation
);

    logic                  ready_q;
    logic                  fire;
    dbm_op_e               op;
    logic                  tgt_open;
    logic [CNT_W:0]        ref_chg;
    logic [CNT_W:0]        refb_chg;
    logic [CNT_W-1:0]      slot_stat [NUM_BANKS];

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end

    assign cmd_ready = ready_q;
    assign fire      = cmd_valid && ready_q;
    assign op        = dbm_op_e'(cmd_op);
    assign tgt_open  = (32'(cmd_bank) < NUM_BANKS) ? bank_open[cmd_bank] : 1'b0;
    assign ref_chg   = (t_rfc > t_rp) ? (CNT_W+1)'(t_rfc - t_rp) : '0;
    assign refb_chg  = (CNT_W+1)'(t_ras) + (CNT_W+1)'(t_rp);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_slot
        dbm_bank_slot #(
            .BANK_W (BANK_W),
            .IDX    (g)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .fire     (fire),
            .op       (op),
            .bank     (cmd_bank),
            .ts       (cmd_ts),
            .ref_chg  (ref_chg),
            .refb_chg (refb_chg),
            .kind     (stat_kind),
            .is_open  (bank_open[g]),
            .stat     (slot_stat[g])
        );
    end

    dbm_device_ctl #(
        .NUM_BANKS (NUM_BANKS)
    ) u_dev (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .op        (op),
        .ts        (cmd_ts),
        .tgt_open  (tgt_open),
        .bank_open (bank_open),
        .ref_chg   (ref_chg),
        .dev_open  (device_open),
        .dev_act   (dev_active_cycles),
        .dev_pre   (dev_precharge_cycles),
        .ref_cnt   (refresh_count),
        .viol      (violation)
    );

    assign stat_value = (32'(stat_bank) < NUM_BANKS) ? slot_stat[stat_bank] : '0;

    // R1: ready rises one edge after reset and stays up
    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> cmd_ready);

endmodule

// File: tb/dram_bank_monitor_tb.sv
`timescale 1ns/1ps
module dram_bank_monitor_tb;

    localparam int  NB   = 8;
    localparam longint MAXC = 64'hFFFF_FFFF;
    localparam int  RFC = 20, RP = 5, RAS = 12;
    localparam longint KREF = 15;   // RFC - RP
    localparam longint KRB  = 17;   // RAS + RP

    logic        clk = 0;
    logic        rst = 1;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 0;
    logic [2:0]  cmd_bank = 0;
    logic [31:0] cmd_ts = 0;
    logic [15:0] t_rfc = RFC[15:0], t_rp = RP[15:0], t_ras = RAS[15:0];
    logic [2:0]  stat_bank = 0;
    logic [2:0]  stat_kind = 0;
    logic [31:0] stat_value;
    logic [NB-1:0] bank_open;
    logic        device_open;
    logic [31:0] dev_active_cycles, dev_precharge_cycles, refresh_count;
    logic        violation;

    always #10 clk = ~clk;   // 50 MHz

    dram_bank_monitor u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_ts(cmd_ts),
        .t_rfc(t_rfc), .t_rp(t_rp), .t_ras(t_ras),
        .stat_bank(stat_bank), .stat_kind(stat_kind), .stat_value(stat_value),
        .bank_open(bank_open), .device_open(device_open),
        .dev_active_cycles(dev_active_cycles),
        .dev_precharge_cycles(dev_precharge_cycles),
        .refresh_count(refresh_count), .violation(violation)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit started = 0;
    int sel    = 0;

    // reference model state
    longint mc [NB][6];
    bit     mo [NB];
    longint mots [NB];
    longint mfirst, mlast, mdact, mdpre, mref;
    bit     mviol, mready;

    function automatic longint sadd(longint a, longint b);
        longint s = a + b;
        return (s > MAXC) ? MAXC : s;
    endfunction

    function automatic longint gapf(longint now, longint since);
        return (now >= since) ? now - since : 0;
    endfunction

    function automatic int nopen();
        int n = 0;
        for (int i = 0; i < NB; i++) n += mo[i];
        return n;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin
            mo[i] = 0; mots[i] = 0;
            for (int k = 0; k < 6; k++) mc[i][k] = 0;
        end
        mfirst = 0; mlast = 0; mdact = 0; mdpre = 0; mref = 0;
        mviol = 0; mready = 0;
    endtask

    task automatic model_apply(int op, int b, longint ts);
        int n = nopen();
        mviol = 0;
        case (op)
            0: if (mo[b]) mviol = 1;
               else begin
                   if (n == 0) begin mfirst = ts; mdpre = sadd(mdpre, gapf(ts, mlast)); end
                   mc[b][0] = sadd(mc[b][0], 1); mo[b] = 1; mots[b] = ts;
               end
            1, 2: begin
                mc[b][op] = sadd(mc[b][op], 1);
                if (!mo[b]) mviol = 1;
            end
            3: if (!mo[b]) mviol = 1;
               else begin
                   mc[b][3] = sadd(mc[b][3], 1);
                   mc[b][5] = sadd(mc[b][5], gapf(ts, mots[b]));
                   if (n == 1) begin mdact = sadd(mdact, gapf(ts, mfirst)); mlast = ts; end
                   mo[b] = 0;
               end
            4: if (n == 0) mviol = 1;
               else begin
                   for (int i = 0; i < NB; i++) if (mo[i]) begin
                       mc[i][3] = sadd(mc[i][3], 1);
                       mc[i][5] = sadd(mc[i][5], gapf(ts, mots[i]));
                       mo[i] = 0;
                   end
                   mdact = sadd(mdact, gapf(ts, mfirst)); mlast = ts;
               end
            5: begin
                if (n > 0) mviol = 1;
                mref  = sadd(mref, 1);
                mdpre = sadd(mdpre, gapf(ts, mlast));
                mlast = ts + KREF;
                mdact = sadd(mdact, KREF);
                for (int i = 0; i < NB; i++) begin
                    mc[i][5] = sadd(mc[i][5], KREF); mo[i] = 0;
                end
            end
            6: if (mo[b]) mviol = 1;
               else begin
                   mc[b][4] = sadd(mc[b][4], 1);
                   mc[b][5] = sadd(mc[b][5], KRB);
               end
            default: mviol = 1;
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else begin
            if (cmd_valid && mready) model_apply(int'(cmd_op), int'(cmd_bank), longint'(cmd_ts));
            else mviol = 0;
            mready = 1;
        end
    end

    task automatic cmp(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic longint exp_stat(int b, int k);
        return (k < 6) ? mc[b][k] : 0;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            cmp("R1 cmd_ready", cmd_ready, 1);
            for (int i = 0; i < NB; i++) cmp("R2 bank_open", bank_open[i], mo[i]);
            cmp("R12 device_open", device_open, nopen() > 0);
            cmp("R5 dev_active_cycles", dev_active_cycles, mdact);
            cmp("R3 dev_precharge_cycles", dev_precharge_cycles, mdpre);
            cmp("R7 refresh_count", refresh_count, mref);
            cmp("R11 violation", violation, mviol);
            cmp("R13 stat_value", stat_value, exp_stat(int'(stat_bank), int'(stat_kind)));
            sel++;
            stat_bank = sel[2:0];
            stat_kind = sel[5:3];
        end
    end

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic issue(int op, int b, longint ts);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op[2:0]; cmd_bank = b[2:0]; cmd_ts = ts[31:0];
        @(posedge clk);
        #1;
        cmd_valid = 0;
    endtask

    task automatic chk_stat(string tag, int b, int k, longint exp);
        logic [2:0] sb, sk;
        sb = stat_bank; sk = stat_kind;
        stat_bank = b[2:0]; stat_kind = k[2:0];
        #1;
        cmp(tag, stat_value, exp);
        stat_bank = sb; stat_kind = sk;
        #1;
    endtask

    initial begin
        longint ts;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        #1;
        // R1: reset state
        cmp("R1 dev_active_cycles reset", dev_active_cycles, 0);
        cmp("R1 dev_precharge_cycles reset", dev_precharge_cycles, 0);
        cmp("R1 refresh_count reset", refresh_count, 0);
        cmp("R1 bank_open reset", bank_open, 0);
        cmp("R1 violation reset", violation, 0);
        cmp("R1 cmd_ready", cmd_ready, 1);
        chk_stat("R1 stat reset", 3, 5, 0);
        started = 1;

        issue(0, 0, 10);
        cmp("R3 closed total at first activate", dev_precharge_cycles, 10);
        chk_stat("R2 activate count", 0, 0, 1);
        cmp("R12 device open", device_open, 1);
        issue(0, 0, 12);
        cmp("R2 duplicate activate flagged", violation, 1);
        chk_stat("R2 duplicate activate not counted", 0, 0, 1);
        issue(1, 0, 14);
        issue(2, 0, 15);
        cmp("R4 legal write not flagged", violation, 0);
        issue(1, 3, 16);
        cmp("R4 read to closed bank flagged", violation, 1);
        chk_stat("R4 read to closed bank counted", 3, 1, 1);
        issue(0, 3, 20);
        issue(3, 0, 30);
        chk_stat("R5 bank0 open cycles", 0, 5, 20);
        cmp("R5 device still open", device_open, 1);
        issue(3, 3, 40);
        cmp("R5 device open total", dev_active_cycles, 30);
        cmp("R12 device quiet after last precharge", device_open, 0);
        issue(3, 3, 41);
        cmp("R5 precharge to closed bank flagged", violation, 1);
        chk_stat("R5 precharge count unchanged", 3, 3, 1);
        issue(4, 0, 42);
        cmp("R6 precharge-all with none open flagged", violation, 1);
        issue(6, 1, 45);
        chk_stat("R8 single-bank refresh adds tRAS+tRP", 1, 5, KRB);
        issue(0, 2, 50);
        cmp("R3 closed total second period", dev_precharge_cycles, 20);
        issue(6, 2, 51);
        cmp("R8 refresh to open bank flagged", violation, 1);
        chk_stat("R8 refresh count unchanged", 2, 4, 0);
        issue(0, 5, 55);
        issue(4, 0, 60);
        cmp("R6 device open total after precharge-all", dev_active_cycles, 40);
        chk_stat("R6 bank2 open cycles", 2, 5, 10);
        chk_stat("R6 bank5 open cycles", 5, 5, 5);
        cmp("R6 all banks closed", bank_open, 0);
        issue(5, 0, 70);
        cmp("R7 refresh count", refresh_count, 1);
        cmp("R7 closed total", dev_precharge_cycles, 30);
        cmp("R7 device open total", dev_active_cycles, 55);
        chk_stat("R7 bank0 open cycles", 0, 5, 35);
        issue(0, 1, 75);
        cmp("R9 early activate adds zero", dev_precharge_cycles, 30);
        issue(5, 0, 80);
        cmp("R7 refresh with open bank flagged", violation, 1);
        cmp("R7 refresh closes banks", bank_open, 0);
        cmp("R9 refresh before closed start adds zero", dev_precharge_cycles, 30);
        issue(7, 2, 81);
        cmp("R11 reserved opcode flagged", violation, 1);
        cmp("R11 reserved opcode no effect", bank_open, 0);
        @(negedge clk);
        cmd_op = 3'd0; cmd_bank = 3'd4; cmd_ts = 32'd90;   // valid stays low
        @(posedge clk);
        #1;
        cmp("R11 idle command ignored", bank_open[4], 0);
        cmp("R11 idle no violation", violation, 0);
        chk_stat("R11 idle activate not counted", 4, 0, 0);

        // random stream
        ts = 100;
        for (int i = 0; i < 600; i++) begin
            ts += $urandom % 4;
            issue(int'($urandom % 8), int'($urandom % NB), ts);
        end

        // saturation
        issue(4, 0, 5000);
        issue(0, 6, 5001);
        issue(3, 6, 64'hFFFF_F000);
        issue(0, 6, 64'hFFFF_F000);
        issue(3, 6, 64'hFFFF_FFFF);
        for (int i = 0; i < 400; i++) issue(6, 6, 64'hFFFF_FFFF);
        chk_stat("R10 open cycles saturate", 6, 5, MAXC);

        repeat (3) @(posedge clk);
        #1;
        summary();
        $finish;
    end

endmodule